// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches a set of external interrupt pins (two by default) for a small microcontroller. Every pin has its own 4-bit control register. The register gates the pin input on or off and picks the active polarity. That polarity also sets the level the CPU polls and the level that wakes the device. The register also chooses whether only the edge that matches the polarity counts, or both edges count. Each pin input passes through a synchroniser. It is then gated and adjusted for polarity into an "active level" signal. A change of that signal sets the pin's request flag. This includes a change caused by a register write to the enable or polarity bit.

A separate interrupt-enable register decides what happens to each flag. When a pin's enable bit is set, the flag drives a request output, and the CPU clears it with an acknowledge. When the enable bit is clear, software polls the flag with a skip-on-flag test, and a successful test clears the flag. Reset clears every register. A back-up entry pulse clears only the interrupt-enable register. The pin 0 control register has an auxiliary bit that is exported as a timer gate, and the block does nothing else with it.

Each pin's flag is a small state machine with two states, FLAG_IDLE and FLAG_PEND. It has three transitions:
- SET: from FLAG_IDLE to FLAG_PEND on a valid edge.
- CLEAR: from FLAG_PEND to FLAG_IDLE on a clear with no edge in the same cycle.
- HOLD: the state stays as it is otherwise, and an edge always wins over a clear.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, both control registers and the interrupt-enable register read 0, and irq_o, wake_o, skip_o and tmr1_gate_o are 0.
- R2: The write/read select chooses the register. Select 0 is pin 0 control and select 1 is pin 1 control. Select 2 is the interrupt-enable register: bit p enables pin p, and bits 3:2 read as 0. Select 3 writes nothing and reads 0. Control bit 0 of pin 1 is stored and read back with no other effect. Control bit 0 of pin 0 drives tmr1_gate_o.
- R3: When control bit 3 (input enable) is 0, pin activity never sets the flag and never asserts wake_o.
- R4: Control bit 2 sets the polarity. With 0, the active level is low and the valid single edge is falling. With 1, the active level is high and the valid single edge is rising.
- R5: When control bit 1 is 1, both a rise and a fall of the active level set the flag, whatever the polarity.
- R6: A write to bit 3 or bit 2 that changes the active level sets the flag, under the same edge rule as a pin change. The flag is set on the clock edge after the write.
- R7: A pin change goes through two synchroniser stages. wake_o follows two clock edges after the change, and the flag is set on the third edge.
- R8: When a pin's interrupt is disabled, the skip test (skip_req_i with skip_sel_i) returns the flag on skip_o and clears it on that clock edge.
- R9: When a pin's interrupt is enabled, the skip test returns 0 and leaves the flag unchanged.
- R10: irq_o[p] is high while the flag is set and the interrupt is enabled. ack_i[p] then clears the flag.
- R11: An edge in the same cycle as a clear (skip or acknowledge) leaves the flag set.
- R12: A back-up pulse clears the interrupt-enable register. It keeps the control registers and the pending flags, and it wins over a same-cycle write to the enable register.
- R13: wake_o is high while any input-enabled pin sits at its selected active level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_i | input | NUM_PINS | Raw external interrupt pins |
| backup_i | input | 1 | Back-up entry pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | SEL_W (2) | Register select for writes |
| wr_data_i | input | 4 | Write data |
| rd_sel_i | input | SEL_W (2) | Register select for reads |
| rd_data_o | output | 4 | Read data |
| skip_req_i | input | 1 | Skip-on-flag test request |
| skip_sel_i | input | PIN_W (1) | Pin tested by the skip |
| skip_o | output | 1 | Skip test result |
| ack_i | input | NUM_PINS | Per-pin interrupt acknowledge |
| irq_o | output | NUM_PINS | Per-pin interrupt request |
| wake_o | output | 1 | Wake-up level present |
| tmr1_gate_o | output | 1 | Timer 1 gating enable from pin 0 control |

## Verification
The assertions assume that inputs change only between clock edges and that skip_sel_i always names an existing pin. They also assume that the acknowledge and skip inputs are each sampled once per clock edge, so a clear and an edge on the same edge are well defined. The stimulus drives every input on the falling clock edge. It keeps skip_sel_i within range, and it also issues writes to the unused select value and random back-up pulses. Directed sequences place an acknowledge on the exact edge where a second synchronised pin edge arrives. This covers the case where an edge and a clear land together.

// File: rtl/extint_pkg.sv
package extint_pkg;
    localparam int CTRL_W    = 4;
    localparam int BIT_IN_EN = 3;
    localparam int BIT_POL   = 2;
    localparam int BIT_BOTH  = 1;
    localparam int BIT_AUX   = 0;

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_PEND = 1'b1
    } flag_state_t;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/extint_pin.sv
module extint_pin
    import extint_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_s_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic              clr_i,
    output logic              act_o,
    output logic              edge_o,
    output logic              flag_o
);
    logic        act_q;
    flag_state_t state_q, state_d;

    // active level: gated input, inverted when polarity selects low
    assign act_o = ctrl_i[BIT_IN_EN] & (pin_s_i ~^ ctrl_i[BIT_POL]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= act_o;
    end

    assign edge_o = ctrl_i[BIT_BOTH] ? (act_o ^ act_q) : (act_o & ~act_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    // next state: SET on edge, CLEAR on clear without edge, else HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: if (edge_o)           state_d = FLAG_PEND;
            FLAG_PEND: if (clr_i && !edge_o) state_d = FLAG_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        flag_o = (state_q == FLAG_PEND);
    end
endmodule

// File: rtl/extint_regs.sv
module extint_regs
    import extint_pkg::*;
#(
    parameter int NUM_PINS = 2,
    parameter int SEL_W    = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en_i,
    input  logic [SEL_W-1:0]                 wr_sel_i,
    input  logic [CTRL_W-1:0]                wr_data_i,
    input  logic                             backup_i,
    input  logic [SEL_W-1:0]                 rd_sel_i,
    output logic [NUM_PINS-1:0][CTRL_W-1:0]  ctrl_o,
    output logic [NUM_PINS-1:0]              ie_o,
    output logic [CTRL_W-1:0]                rd_data_o
);
    localparam logic [SEL_W-1:0] IE_SEL = SEL_W'(NUM_PINS);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_ctrl
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ctrl_o[p] <= '0;
            else if (wr_en_i && wr_sel_i == SEL_W'(p))
                ctrl_o[p] <= wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ie_o <= '0;
        else if (backup_i)
            ie_o <= '0;
        else if (wr_en_i && wr_sel_i == IE_SEL)
            ie_o <= wr_data_i[NUM_PINS-1:0];
    end

    always_comb begin
        rd_data_o = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (rd_sel_i == SEL_W'(p)) rd_data_o = ctrl_o[p];
        end
        if (rd_sel_i == IE_SEL) rd_data_o[NUM_PINS-1:0] = ie_o;
    end
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int NUM_PINS    = 2,
    parameter int SYNC_STAGES = 2,
    parameter int SEL_W       = $clog2(NUM_PINS + 1),
    parameter int PIN_W       = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PINS-1:0]  pin_i,
    input  logic                 backup_i,
    input  logic                 wr_en_i,
    input  logic [SEL_W-1:0]     wr_sel_i,
    input  logic [CTRL_W-1:0]    wr_data_i,
    input  logic [SEL_W-1:0]     rd_sel_i,
    output logic [CTRL_W-1:0]    rd_data_o,
    input  logic                 skip_req_i,
    input  logic [PIN_W-1:0]     skip_sel_i,
    output logic                 skip_o,
    input  logic [NUM_PINS-1:0]  ack_i,
    output logic [NUM_PINS-1:0]  irq_o,
    output logic                 wake_o,
    output logic                 tmr1_gate_o
);
    logic [NUM_PINS-1:0][CTRL_W-1:0] ctrl_w;
    logic [NUM_PINS-1:0]             ie_w;
    logic [NUM_PINS-1:0]             sync_w;
    logic [NUM_PINS-1:0]             act_w;
    logic [NUM_PINS-1:0]             edge_w;
    logic [NUM_PINS-1:0]             flag_w;
    logic [NUM_PINS-1:0]             clr_w;

    extint_regs #(
        .NUM_PINS (NUM_PINS),
        .SEL_W    (SEL_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .backup_i  (backup_i),
        .rd_sel_i  (rd_sel_i),
        .ctrl_o    (ctrl_w),
        .ie_o      (ie_w),
        .rd_data_o (rd_data_o)
    );

    // skip test valid only for a disabled interrupt with a pending flag
    assign skip_o = skip_req_i & ~ie_w[skip_sel_i] & flag_w[skip_sel_i];

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        extint_sync #(.STAGES(SYNC_STAGES)) sync_i (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (pin_i[p]),
            .q_o   (sync_w[p])
        );

        assign clr_w[p] = (skip_o && skip_sel_i == PIN_W'(p))
                        | (ack_i[p] & ie_w[p] & flag_w[p]);

        extint_pin pin_u (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_s_i (sync_w[p]),
            .ctrl_i  (ctrl_w[p]),
            .clr_i   (clr_w[p]),
            .act_o   (act_w[p]),
            .edge_o  (edge_w[p]),
            .flag_o  (flag_w[p])
        );
    end

    assign irq_o       = flag_w & ie_w;
    assign wake_o      = |act_w;
    assign tmr1_gate_o = ctrl_w[0][BIT_AUX];
endmodule

// File: rtl/extint_ctrl_chk.sv
module extint_ctrl_chk
    import extint_pkg::*;
#(
    parameter int NUM_PINS = 2,
    parameter int PIN_W    = 1
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            backup_i,
    input logic                            wr_en_i,
    input logic                            skip_o,
    input logic [PIN_W-1:0]                skip_sel_i,
    input logic [NUM_PINS-1:0]             irq_o,
    input logic [NUM_PINS-1:0]             ack_i,
    input logic                            wake_o,
    input logic [NUM_PINS-1:0][CTRL_W-1:0] ctrl_i,
    input logic [NUM_PINS-1:0]             ie_i,
    input logic [NUM_PINS-1:0]             flag_i,
    input logic [NUM_PINS-1:0]             edge_i
);
    logic any_in_en;
    always_comb begin
        any_in_en = 1'b0;
        for (int p = 0; p < NUM_PINS; p++) any_in_en |= ctrl_i[p][BIT_IN_EN];
    end

    AST_SKIP_NOT_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        skip_o |-> !irq_o[skip_sel_i]); // R9

    AST_BACKUP_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        backup_i |=> (ie_i == '0)); // R12

    AST_BACKUP_KEEPS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (backup_i && !wr_en_i) |=> $stable(ctrl_i)); // R12

    AST_WAKE_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> any_in_en); // R13

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
        AST_SKIP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (skip_o && skip_sel_i == PIN_W'(p) && !edge_i[p]) |=> !flag_i[p]); // R8

        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_i[p] && irq_o[p] && !edge_i[p]) |=> !irq_o[p]); // R10

        AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            edge_i[p] |=> flag_i[p]); // R11
    end
endmodule

bind extint_ctrl extint_ctrl_chk #(
    .NUM_PINS (NUM_PINS),
    .PIN_W    (PIN_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .backup_i   (backup_i),
    .wr_en_i    (wr_en_i),
    .skip_o     (skip_o),
    .skip_sel_i (skip_sel_i),
    .irq_o      (irq_o),
    .ack_i      (ack_i),
    .wake_o     (wake_o),
    .ctrl_i     (ctrl_w),
    .ie_i       (ie_w),
    .flag_i     (flag_w),
    .edge_i     (edge_w)
);

// File: tb/extint_ctrl_tb_top.sv
module extint_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pin_i = 2'b11;
    logic       backup_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [1:0] wr_sel_i = '0;
    logic [3:0] wr_data_i = '0;
    logic [1:0] rd_sel_i = '0;
    logic [3:0] rd_data_o;
    logic       skip_req_i = 1'b0;
    logic [0:0] skip_sel_i = '0;
    logic       skip_o;
    logic [1:0] ack_i = '0;
    logic [1:0] irq_o;
    logic       wake_o;
    logic       tmr1_gate_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    extint_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .backup_i(backup_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
        .skip_req_i(skip_req_i), .skip_sel_i(skip_sel_i), .skip_o(skip_o),
        .ack_i(ack_i), .irq_o(irq_o), .wake_o(wake_o), .tmr1_gate_o(tmr1_gate_o)
    );

    // ---------------- behavioural reference model ----------------
    logic [3:0] m_ctrl [2];
    logic [1:0] m_ie;
    int         m_dly  [2][$];   // pin history, oldest first
    bit         m_last [2];
    bit         m_flag [2];

    function automatic bit m_sync(int p);
        return (m_dly[p].size() >= 2) ? m_dly[p][0] : 1'b0;
    endfunction

    function automatic bit m_act(int p);
        if (!m_ctrl[p][3]) return 1'b0;
        return m_sync(p) == m_ctrl[p][2];
    endfunction

    function automatic bit m_skip();
        return skip_req_i && !m_ie[skip_sel_i] && m_flag[skip_sel_i];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < 2; p++) begin
                m_ctrl[p] = '0; m_last[p] = 0; m_flag[p] = 0;
                m_dly[p].delete();
            end
            m_ie = '0;
        end else begin
            bit nf [2];
            bit sk;
            sk = m_skip();
            for (int p = 0; p < 2; p++) begin
                bit a, e, c;
                a = m_act(p);
                e = m_ctrl[p][1] ? (a != m_last[p]) : (a && !m_last[p]);
                c = (sk && skip_sel_i == p) || (ack_i[p] && m_ie[p] && m_flag[p]);
                nf[p] = e || (m_flag[p] && !c);
                m_last[p] = a;
            end
            for (int p = 0; p < 2; p++) begin
                m_flag[p] = nf[p];
                if (m_dly[p].size() >= 2) void'(m_dly[p].pop_front());
                m_dly[p].push_back(int'(pin_i[p]));
            end
            if (wr_en_i && wr_sel_i < 2) m_ctrl[wr_sel_i] = wr_data_i;
            if (backup_i) m_ie = '0;
            else if (wr_en_i && wr_sel_i == 2) m_ie = wr_data_i[1:0];
        end
    end

    task automatic chk(input string tag, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, actual, expected, $time);
        end
    endtask

    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            logic [3:0] erd;
            erd = (rd_sel_i < 2) ? m_ctrl[rd_sel_i] :
                  (rd_sel_i == 2) ? {2'b00, m_ie} : 4'h0;
            chk("R10 irq_o model", int'(irq_o), int'({m_flag[1] & m_ie[1], m_flag[0] & m_ie[0]}));
            chk("R8 skip_o model", int'(skip_o), int'(m_skip()));
            chk("R13 wake_o model", int'(wake_o), int'(m_act(0) || m_act(1)));
            chk("R2 rd_data_o model", int'(rd_data_o), int'(erd));
            chk("R2 tmr1_gate_o model", int'(tmr1_gate_o), int'(m_ctrl[0][0]));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [3:0] data);
        wr_en_i = 1; wr_sel_i = sel; wr_data_i = data;
        tick();
        wr_en_i = 0;
    endtask

    task automatic probe(input int p, input int expected, input string tag);
        skip_req_i = 1; skip_sel_i = 1'(p);
        #1;
        chk(tag, int'(skip_o), expected);
        skip_req_i = 0;
    endtask

    task automatic consume(input int p);
        skip_req_i = 1; skip_sel_i = 1'(p);
        tick();
        skip_req_i = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst_n = 1;
        tick(3);
        // R1 reset state
        for (int s = 0; s < 3; s++) begin
            rd_sel_i = 2'(s); #1;
            chk("R1 register reset value", int'(rd_data_o), 0);
        end
        chk("R1 irq_o reset", int'(irq_o), 0);
        chk("R1 wake_o reset", int'(wake_o), 0);
        chk("R1 tmr1_gate_o reset", int'(tmr1_gate_o), 0);

        // R2 register access
        wr(1, 4'b0001);
        rd_sel_i = 1; #1;
        chk("R2 pin1 bit0 readback", int'(rd_data_o), 1);
        chk("R2 pin1 bit0 no timer effect", int'(tmr1_gate_o), 0);
        wr(0, 4'b0001); #1;
        chk("R2 timer gate from pin0 bit0", int'(tmr1_gate_o), 1);
        wr(0, 4'b0000);
        wr(2, 4'b1111);
        rd_sel_i = 2; #1;
        chk("R2 enable reg upper bits zero", int'(rd_data_o), 3);
        wr(3, 4'b1111);
        rd_sel_i = 3; #1;
        chk("R2 unused select reads zero", int'(rd_data_o), 0);
        wr(2, 4'b0000);

        // R4 falling polarity, single edge
        wr(0, 4'b1000);
        probe(0, 0, "R4 high level inactive");
        pin_i[0] = 0;
        tick(); #1;
        chk("R7 wake not yet after one edge", int'(wake_o), 0);
        tick(); #1;
        chk("R13 wake at low return level", int'(wake_o), 1);
        probe(0, 0, "R7 flag not yet after two edges");
        tick();
        probe(0, 1, "R4 falling edge sets flag");
        consume(0);
        probe(0, 0, "R8 skip clears flag");
        pin_i[0] = 1;
        tick(4);
        probe(0, 0, "R4 rising edge ignored in falling mode");

        // R5 both edges
        wr(0, 4'b1010);
        pin_i[0] = 0; tick(3);
        probe(0, 1, "R5 fall sets flag");
        consume(0);
        pin_i[0] = 1; tick(3);
        probe(0, 1, "R5 rise sets flag");
        consume(0);

        // R6 polarity write sets flag
        wr(0, 4'b1000);
        wr(0, 4'b1100);
        probe(0, 0, "R6 flag one edge after write");
        tick();
        probe(0, 1, "R6 polarity write sets flag");
        consume(0);

        // R3 input disabled
        wr(0, 4'b0100);
        pin_i[0] = 0; tick(2);
        pin_i[0] = 1; tick(4);
        probe(0, 0, "R3 disabled input no flag");
        #1 chk("R3 disabled input no wake", int'(wake_o), 0);

        // R9 / R10
        wr(2, 4'b0001);
        wr(0, 4'b1100);
        tick(); #1;
        chk("R10 irq with flag and enable", int'(irq_o[0]), 1);
        skip_req_i = 1; skip_sel_i = 0; #1;
        chk("R9 skip invalid when enabled", int'(skip_o), 0);
        tick(); skip_req_i = 0; #1;
        chk("R9 flag kept after invalid skip", int'(irq_o[0]), 1);
        ack_i = 2'b01; tick(); ack_i = 0; #1;
        chk("R10 ack clears flag", int'(irq_o[0]), 0);

        // R11 edge and clear together
        wr(0, 4'b1110);
        pin_i[0] = 0; tick();
        pin_i[0] = 1; tick(2); #1;
        chk("R11 first edge flag", int'(irq_o[0]), 1);
        ack_i = 2'b01; tick(); ack_i = 0; #1;
        chk("R11 edge beats ack", int'(irq_o[0]), 1);
        ack_i = 2'b01; tick(); ack_i = 0; #1;
        chk("R10 later ack clears", int'(irq_o[0]), 0);

        // R12 back-up entry
        pin_i[0] = 0; tick(3); #1;
        chk("R12 flag pending before backup", int'(irq_o[0]), 1);
        backup_i = 1; wr_en_i = 1; wr_sel_i = 2; wr_data_i = 4'b0011;
        tick(); backup_i = 0; wr_en_i = 0; #1;
        chk("R12 backup drops irq", int'(irq_o[0]), 0);
        rd_sel_i = 2; #1;
        chk("R12 enable reg cleared", int'(rd_data_o), 0);
        rd_sel_i = 0; #1;
        chk("R12 control reg kept", int'(rd_data_o), 4'b1110);
        probe(0, 1, "R12 flag kept");
        consume(0);

        // R13 pin1 high level
        wr(1, 4'b1100); #1;
        chk("R13 wake on pin1 high", int'(wake_o), 1);
        pin_i[1] = 0; tick(2); #1;
        chk("R13 wake drops", int'(wake_o), 0);

        // random phase, compared against the model every cycle
        for (int i = 0; i < 4000; i++) begin
            pin_i      = 2'($urandom);
            wr_en_i    = ($urandom % 4) == 0;
            wr_sel_i   = 2'($urandom);
            wr_data_i  = 4'($urandom);
            backup_i   = ($urandom % 32) == 0;
            skip_req_i = ($urandom % 4) == 0;
            skip_sel_i = 1'($urandom);
            ack_i      = 2'($urandom) & 2'($urandom);
            rd_sel_i   = 2'($urandom);
            tick();
        end
        wr_en_i = 0; backup_i = 0; skip_req_i = 0; ack_i = 0;
        tick(2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule